// File: doc/BRIEF.md
# Audio Bus-Master Register Interface

This block is the host-side register file of a three-stream audio DMA engine. The streams are capture, playback and microphone. A host reaches it through a 64-byte I/O window with byte, word and dword accesses. Each stream has a descriptor base pointer, a current index, a prefetch index, a last-valid index, a status register and a control register. A global control register and a global status register complete the map. Register writes have side effects: a stream starts, restarts after a halt, or is reset. These actions reach the stream engine as single-cycle strobes and as a run level. The engine reports a halt back on one input line per stream.

Each stream has a small state machine. STOPPED is the state after reset, after a cold reset, after a stream reset, and after any control write with run clear. RUNNING is entered from STOPPED or HALTED by a control write with run set. RUNNING also follows a last-valid-index write while the stream is HALTED. HALTED is entered from RUNNING when the engine halt input pulses. The halted status bit reads one in STOPPED and in HALTED. A read returns its data on `bus_rdata` one cycle after `bus_rd`. Two free-running 16-bit counters record host accesses that hit no implemented register.

Top module: `audma_regs`

## Requirements
- R1: The stream number is address bits [5:4]; slots 0x00, 0x10 and 0x20 are streams 0 to 2. Address 0x2C is global control and is decoded ahead of stream 2's slot. Address 0x30 is global status. Byte reads of 0x34 return zero.
- R2: A dword write to stream offset 0x0 stores the descriptor base with bits [1:0] forced to zero.
- R3: A byte write to the last-valid index at offset 0x5 stores the low 5 bits of the data (modulo 32). In HALTED the same write clears the halted bit (status bit 0) and the last-entry bit (status bit 1). It also copies the prefetch index into the current index, increments the prefetch index modulo 32 (31 wraps to 0) and returns the stream to RUNNING.
- R4: A byte write to control at offset 0xB with bit 1 set zeroes base, indices, control and status flags. The stream goes to STOPPED with the halted bit set, and `strm_clr` pulses for one cycle. The written value is not stored.
- R5: A byte control write with bit 1 clear stores data AND 0x1D; bit 0 is run. With run clear the stream stops and the halted bit sets. With run set the current index takes the prefetch index and the prefetch index increments modulo 32. The halted bit then clears and `strm_start` pulses for one cycle. `strm_run` mirrors control bit 0.
- R6: A byte or word write to status at offset 0x6 clears status bit 2 when data bit 2 is one. Status bits 0 and 1 cannot be written.
- R7: In RUNNING, an `eng_halt` pulse moves the stream to HALTED and sets status bits 1 and 2. In STOPPED or HALTED the pulse has no effect.
- R8: A dword write to global control with bit 2 set pulses `link_warm`. With bit 1 set it pulses `link_cold` and returns all three streams to their reset state. Only when both bits are clear is the value stored, masked with 0xF9.
- R9: Global status reads as {8'h0, sticky[7:0], flags[7:0], gsta_ro[7:0]}. A write clears each flag written as one and ORs data bits [23:16] into the sticky bits. Bits [7:0] are read-only. A `gsta_evt` bit sets its flag, and a set in the same cycle as a clear wins.
- R10: Reads: a byte read at offset 0x4/0x5/0x6/0xA/0xB returns the current index, last index, status low byte, prefetch index or control. A word read at 0x6/0x8 returns status or position (always 0). A dword read at 0x0/0x4/0x8 returns the base, {status, last, current} or {control, prefetch, 16'h0}, each index in its own byte. Any other address or size reads 0xFFFFFFFF.
- R11: `unimp_rd_cnt` and `unimp_wr_cnt` each increment by one for every read or write that hits no implemented register. Both wrap at 16 bits.
- R12: After reset every stream is STOPPED with status 0x0001 and all other registers are zero. The strobes are low and the counters are zero.
- R13: Sizes are decoded strictly: 0 byte, 1 word, 2 dword, 3 invalid. Last-valid index and control accept only bytes, and base and the global registers only dwords. A write of any other size leaves state unchanged and counts as unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 6 | Byte address in the window |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| eng_halt | input | 3 | Per-stream halt report from the engine |
| gsta_evt | input | 8 | Set pulses for the global status flags |
| gsta_ro | input | 8 | Live read-only global status bits |
| strm_run | output | 3 | Per-stream run level |
| strm_start | output | 3 | Per-stream start/fetch strobe |
| strm_clr | output | 3 | Per-stream reset strobe |
| link_warm | output | 1 | Warm reset strobe |
| link_cold | output | 1 | Cold reset strobe |
| unimp_rd_cnt | output | 16 | Unimplemented read count |
| unimp_wr_cnt | output | 16 | Unimplemented write count |

## Verification
The bench targets several corner cases.

- Global control: it sits at 0x2C inside stream 2's slot. A decoder that checks the stream slot first would turn a global write into a stray stream access, and the cold reset would never reach the streams.
- Index wrap: repeated halt and restart cycles walk the prefetch index past 31. A design that does not wrap modulo 32 shows a wrong index byte on the next dword read.
- Restart after a halt: a last-valid-index write to a STOPPED stream must not advance anything. A write to a HALTED stream must advance both indices.
- Stream reset: a reset control write must leave control at zero, not the written pattern.
- Access sizes: the wrong access sizes on base, control and last-valid index must leave state alone and raise the write counter.
- Status bits: write-one-to-clear and read-only status bits must survive writes of all ones.

// File: rtl/audma_pkg.sv
package audma_pkg;
    localparam int NSTRM  = 3;
    localparam int IDX_W  = 5;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 6;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        S_STOP = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2
    } strm_state_e;

    // per-stream slot offsets
    localparam logic [3:0] OFF_BASE = 4'h0;
    localparam logic [3:0] OFF_CUR  = 4'h4;
    localparam logic [3:0] OFF_LAST = 4'h5;
    localparam logic [3:0] OFF_STS  = 4'h6;
    localparam logic [3:0] OFF_POS  = 4'h8;
    localparam logic [3:0] OFF_PRE  = 4'hA;
    localparam logic [3:0] OFF_CTL  = 4'hB;

    // global addresses
    localparam logic [ADDR_W-1:0] ADDR_GCTL  = 6'h2C;
    localparam logic [ADDR_W-1:0] ADDR_GSTA  = 6'h30;
    localparam logic [ADDR_W-1:0] ADDR_CODEC = 6'h34;

    localparam int          CTL_RUN  = 0;
    localparam int          CTL_RST  = 1;
    localparam logic [7:0]  CTL_MASK = 8'h1D;
    localparam int          STS_LAST_IRQ = 2;
    localparam int          GC_COLD  = 1;
    localparam int          GC_WARM  = 2;
    localparam logic [31:0] GC_MASK  = 32'h0000_00F9;
endpackage

// File: rtl/audma_decode.sv
module audma_decode
    import audma_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic              is_strm,
    output logic [1:0]        sidx,
    output logic [3:0]        off,
    output logic              wr_hit,
    output logic              rd_hit
);
    always_comb begin
        sidx    = addr[5:4];
        off     = addr[3:0];
        // global control overlays stream 2's slot and must win
        is_strm = (addr[5:4] < 2'(NSTRM)) && (addr != ADDR_GCTL);
        wr_hit  = 1'b0;
        rd_hit  = 1'b0;
        if (is_strm) begin
            unique case (size)
                SZ_BYTE: begin
                    wr_hit = (off == OFF_LAST) || (off == OFF_STS) || (off == OFF_CTL);
                    rd_hit = (off == OFF_CUR) || (off == OFF_LAST) || (off == OFF_STS) ||
                             (off == OFF_PRE) || (off == OFF_CTL);
                end
                SZ_WORD: begin
                    wr_hit = (off == OFF_STS);
                    rd_hit = (off == OFF_STS) || (off == OFF_POS);
                end
                SZ_DWORD: begin
                    wr_hit = (off == OFF_BASE);
                    rd_hit = (off == OFF_BASE) || (off == OFF_CUR) || (off == OFF_POS);
                end
                default: ;
            endcase
        end else begin
            unique case (size)
                SZ_DWORD: begin
                    wr_hit = (addr == ADDR_GCTL) || (addr == ADDR_GSTA);
                    rd_hit = wr_hit;
                end
                SZ_BYTE:  rd_hit = (addr == ADDR_CODEC);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/audma_stream.sv
module audma_stream
    import audma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cold_clr,
    input  logic        wr_sel,
    input  acc_size_e   size,
    input  logic [3:0]  off,
    input  logic [31:0] wdata,
    input  logic        eng_halt,
    output logic [31:0] base,
    output idx_t        civ,
    output idx_t        lvi,
    output idx_t        piv,
    output logic [7:0]  ctl,
    output logic [15:0] stat,
    output logic        run,
    output logic        start_p,
    output logic        clr_p
);
    strm_state_e st, st_nxt;
    logic celv, lvbci;

    logic base_wr, lvi_wr, ctl_wr, sts_wr;
    logic rst_cmd, go_cmd, stop_cmd, restart, halt_evt;

    always_comb begin
        base_wr  = wr_sel && (size == SZ_DWORD) && (off == OFF_BASE);
        lvi_wr   = wr_sel && (size == SZ_BYTE)  && (off == OFF_LAST);
        ctl_wr   = wr_sel && (size == SZ_BYTE)  && (off == OFF_CTL);
        sts_wr   = wr_sel && ((size == SZ_BYTE) || (size == SZ_WORD)) && (off == OFF_STS);
        rst_cmd  = ctl_wr && wdata[CTL_RST];
        go_cmd   = ctl_wr && !wdata[CTL_RST] && wdata[CTL_RUN];
        stop_cmd = ctl_wr && !wdata[CTL_RST] && !wdata[CTL_RUN];
        restart  = lvi_wr && (st == S_HALT);
        halt_evt = eng_halt && (st == S_RUN) && !ctl_wr;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_STOP: if (go_cmd) st_nxt = S_RUN;
            S_RUN: begin
                if (rst_cmd || stop_cmd) st_nxt = S_STOP;
                else if (halt_evt)       st_nxt = S_HALT;
            end
            S_HALT: begin
                if (rst_cmd || stop_cmd)   st_nxt = S_STOP;
                else if (go_cmd || restart) st_nxt = S_RUN;
            end
            default: st_nxt = S_STOP;
        endcase
        if (cold_clr) st_nxt = S_STOP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_STOP;
        else        st <= st_nxt;
    end

    // register contents and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0; civ <= '0; lvi <= '0; piv <= '0; ctl <= '0;
            celv <= 1'b0; lvbci <= 1'b0; start_p <= 1'b0; clr_p <= 1'b0;
        end else if (cold_clr) begin
            base <= '0; civ <= '0; lvi <= '0; piv <= '0; ctl <= '0;
            celv <= 1'b0; lvbci <= 1'b0; start_p <= 1'b0; clr_p <= 1'b0;
        end else begin
            start_p <= go_cmd;
            clr_p   <= rst_cmd;
            if (base_wr) base <= {wdata[31:2], 2'b00};
            if (lvi_wr)  lvi  <= wdata[IDX_W-1:0];
            if (restart) begin
                civ  <= piv;
                piv  <= piv + 1'b1;
                celv <= 1'b0;
            end
            if (sts_wr && wdata[STS_LAST_IRQ]) lvbci <= 1'b0;
            if (halt_evt) begin
                celv  <= 1'b1;
                lvbci <= 1'b1;
            end
            if (rst_cmd) begin
                base <= '0; civ <= '0; lvi <= '0; piv <= '0; ctl <= '0;
                celv <= 1'b0; lvbci <= 1'b0;
            end else if (ctl_wr) begin
                ctl <= wdata[7:0] & CTL_MASK;
                if (go_cmd) begin
                    civ <= piv;
                    piv <= piv + 1'b1;
                end
            end
        end
    end

    assign stat = {13'b0, lvbci, celv, (st != S_RUN)};
    assign run  = ctl[CTL_RUN];

    // R2
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base[1:0] == 2'b00);
    // R5
    run_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run == (st != S_STOP));
    // R3
    index_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_STOP) |-> (piv == idx_t'(civ + 1'b1)));
    // R3
    restart_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (civ == $past(piv)) && (st == S_RUN));
    // R7
    stop_ignores_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STOP) |=> (st != S_HALT));
endmodule

// File: rtl/audma_global.sv
module audma_global
    import audma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic [31:0]       wdata,
    input  logic [7:0]        gsta_evt,
    input  logic [7:0]        gsta_ro,
    output logic [31:0]       gctl,
    output logic [31:0]       gsta,
    output logic              cold_req,
    output logic              warm_p,
    output logic              cold_p
);
    logic [7:0] flags, sticky;
    logic gctl_wr, gsta_wr;

    always_comb begin
        gctl_wr  = wr && (size == SZ_DWORD) && (addr == ADDR_GCTL);
        gsta_wr  = wr && (size == SZ_DWORD) && (addr == ADDR_GSTA);
        cold_req = gctl_wr && wdata[GC_COLD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gctl   <= '0;
            flags  <= '0;
            sticky <= '0;
            warm_p <= 1'b0;
            cold_p <= 1'b0;
        end else begin
            warm_p <= gctl_wr && wdata[GC_WARM];
            cold_p <= cold_req;
            if (gctl_wr && !wdata[GC_WARM] && !wdata[GC_COLD])
                gctl <= wdata & GC_MASK;
            if (gsta_wr) begin
                flags  <= (flags & ~wdata[15:8]) | gsta_evt;
                sticky <= sticky | wdata[23:16];
            end else begin
                flags  <= flags | gsta_evt;
            end
        end
    end

    assign gsta = {8'h00, sticky, flags, gsta_ro};

    // R9
    no_spont_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(gsta_evt)) == 8'h00);
    // R8
    gctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gctl_wr |=> $stable(gctl));
endmodule

// File: rtl/audma_regs.sv
module audma_regs
    import audma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSTRM-1:0]  eng_halt,
    input  logic [7:0]        gsta_evt,
    input  logic [7:0]        gsta_ro,
    output logic [NSTRM-1:0]  strm_run,
    output logic [NSTRM-1:0]  strm_start,
    output logic [NSTRM-1:0]  strm_clr,
    output logic              link_warm,
    output logic              link_cold,
    output logic [CNT_W-1:0]  unimp_rd_cnt,
    output logic [CNT_W-1:0]  unimp_wr_cnt
);
    acc_size_e   sz;
    logic        is_strm, wr_hit, rd_hit, cold_req;
    logic [1:0]  sidx;
    logic [3:0]  off;
    logic [31:0] gctl, gsta, rd_mux;

    logic [31:0] s_base [NSTRM];
    idx_t        s_civ  [NSTRM];
    idx_t        s_lvi  [NSTRM];
    idx_t        s_piv  [NSTRM];
    logic [7:0]  s_ctl  [NSTRM];
    logic [15:0] s_stat [NSTRM];

    assign sz = acc_size_e'(bus_size);

    audma_decode u_dec (
        .addr(bus_addr), .size(sz), .is_strm(is_strm), .sidx(sidx),
        .off(off), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    audma_global u_glb (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .size(sz),
        .wdata(bus_wdata), .gsta_evt(gsta_evt), .gsta_ro(gsta_ro),
        .gctl(gctl), .gsta(gsta), .cold_req(cold_req),
        .warm_p(link_warm), .cold_p(link_cold)
    );

    for (genvar i = 0; i < NSTRM; i++) begin : g_strm
        audma_stream u_strm (
            .clk(clk), .rst_n(rst_n), .cold_clr(cold_req),
            .wr_sel(bus_wr && is_strm && wr_hit && (sidx == 2'(i))),
            .size(sz), .off(off), .wdata(bus_wdata), .eng_halt(eng_halt[i]),
            .base(s_base[i]), .civ(s_civ[i]), .lvi(s_lvi[i]), .piv(s_piv[i]),
            .ctl(s_ctl[i]), .stat(s_stat[i]), .run(strm_run[i]),
            .start_p(strm_start[i]), .clr_p(strm_clr[i])
        );
    end

    always_comb begin
        rd_mux = '1;
        if (rd_hit && is_strm) begin
            unique case (sz)
                SZ_BYTE: begin
                    case (off)
                        OFF_CUR:  rd_mux = 32'(s_civ[sidx]);
                        OFF_LAST: rd_mux = 32'(s_lvi[sidx]);
                        OFF_STS:  rd_mux = 32'(s_stat[sidx][7:0]);
                        OFF_PRE:  rd_mux = 32'(s_piv[sidx]);
                        default:  rd_mux = 32'(s_ctl[sidx]);
                    endcase
                end
                SZ_WORD: rd_mux = (off == OFF_STS) ? 32'(s_stat[sidx]) : 32'h0;
                SZ_DWORD: begin
                    case (off)
                        OFF_BASE: rd_mux = s_base[sidx];
                        OFF_CUR:  rd_mux = {s_stat[sidx], 8'(s_lvi[sidx]), 8'(s_civ[sidx])};
                        default:  rd_mux = {s_ctl[sidx], 8'(s_piv[sidx]), 16'h0};
                    endcase
                end
                default: rd_mux = '1;
            endcase
        end else if (rd_hit) begin
            if (bus_addr == ADDR_GCTL)      rd_mux = gctl;
            else if (bus_addr == ADDR_GSTA) rd_mux = gsta;
            else                            rd_mux = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata    <= '0;
            unimp_rd_cnt <= '0;
            unimp_wr_cnt <= '0;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;
            if (bus_rd && !rd_hit) unimp_rd_cnt <= unimp_rd_cnt + 1'b1;
            if (bus_wr && !wr_hit) unimp_wr_cnt <= unimp_wr_cnt + 1'b1;
        end
    end

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strm_start));
    // R11
    rd_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unimp_rd_cnt == $past(unimp_rd_cnt)) ||
        (unimp_rd_cnt == $past(unimp_rd_cnt) + 1'b1));
    // R11
    wr_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unimp_wr_cnt == $past(unimp_wr_cnt)) ||
        (unimp_wr_cnt == $past(unimp_wr_cnt) + 1'b1));
    // R4
    clr_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_clr & strm_run) == '0);
endmodule

// File: tb/test_audma_regs.sv
module test_audma_regs;
    localparam logic [1:0] BY = 2'd0, WD = 2'd1, DW = 2'd2, BADSZ = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [1:0]  b_size = '0;
    logic [31:0] b_wdata = '0;
    logic [2:0]  b_halt = '0;
    logic [7:0]  b_evt = '0;
    logic [7:0]  b_ro = 8'h5A;

    logic [31:0] bus_rdata;
    logic [2:0]  strm_run, strm_start, strm_clr;
    logic        link_warm, link_cold;
    logic [15:0] unimp_rd_cnt, unimp_wr_cnt;

    audma_regs i_audma_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_size(b_size), .bus_wdata(b_wdata), .bus_rdata(bus_rdata),
        .eng_halt(b_halt), .gsta_evt(b_evt), .gsta_ro(b_ro),
        .strm_run(strm_run), .strm_start(strm_start), .strm_clr(strm_clr),
        .link_warm(link_warm), .link_cold(link_cold),
        .unimp_rd_cnt(unimp_rd_cnt), .unimp_wr_cnt(unimp_wr_cnt)
    );

    always #4 clk = ~clk;  // 125 MHz

    int    errs = 0, nchk = 0, cyc = 0;
    string cur_req = "R12";

    // behavioural reference model
    logic [31:0] m_base [3];
    int          m_civ [3], m_lvi [3], m_piv [3], m_ctl [3], m_st [3];  // st: 0 stop, 1 run, 2 halt
    bit          m_celv [3], m_lvbci [3];
    logic [31:0] m_gctl;
    logic [7:0]  m_flags, m_sticky;
    int          m_crd, m_cwr;
    logic [31:0] m_rdata;
    bit          m_rdv;
    logic [2:0]  m_start, m_clr;
    bit          m_warm, m_cold;

    function automatic int sr_of(int s);
        return ((m_st[s] != 1) ? 1 : 0) | (m_celv[s] ? 2 : 0) | (m_lvbci[s] ? 4 : 0);
    endfunction

    function automatic void clear_stream(int s);
        m_base[s] = 0; m_civ[s] = 0; m_lvi[s] = 0; m_piv[s] = 0; m_ctl[s] = 0;
        m_st[s] = 0; m_celv[s] = 0; m_lvbci[s] = 0;
    endfunction

    function automatic logic [31:0] model_read(logic [5:0] a, logic [1:0] sz);
        int s = int'(a[5:4]);
        int o = int'(a[3:0]);
        if (s < 3 && a != 6'h2C) begin
            if (sz == BY) begin
                if (o == 4) return 32'(m_civ[s]);
                if (o == 5) return 32'(m_lvi[s]);
                if (o == 6) return 32'(sr_of(s) & 8'hFF);
                if (o == 10) return 32'(m_piv[s]);
                if (o == 11) return 32'(m_ctl[s]);
            end else if (sz == WD) begin
                if (o == 6) return 32'(sr_of(s));
                if (o == 8) return 32'h0;
            end else if (sz == DW) begin
                if (o == 0) return m_base[s];
                if (o == 4) return 32'((sr_of(s) << 16) | (m_lvi[s] << 8) | m_civ[s]);
                if (o == 8) return 32'((m_ctl[s] << 24) | (m_piv[s] << 16));
            end
        end else begin
            if (sz == DW && a == 6'h2C) return m_gctl;
            if (sz == DW && a == 6'h30) return {8'h00, m_sticky, m_flags, b_ro};
            if (sz == BY && a == 6'h34) return 32'h0;
        end
        m_crd = (m_crd + 1) & 16'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic void model_write(logic [5:0] a, logic [1:0] sz, logic [31:0] d);
        int s = int'(a[5:4]);
        int o = int'(a[3:0]);
        bit hit = 0;
        if (s < 3 && a != 6'h2C) begin
            if (sz == BY && o == 5) begin
                hit = 1;
                m_lvi[s] = int'(d[4:0]);
                if (m_st[s] == 2) begin
                    m_st[s] = 1; m_celv[s] = 0;
                    m_civ[s] = m_piv[s]; m_piv[s] = (m_piv[s] + 1) % 32;
                end
            end else if (sz == BY && o == 11) begin
                hit = 1;
                if (d[1]) begin
                    clear_stream(s); m_clr[s] = 1;
                end else begin
                    m_ctl[s] = int'(d[7:0] & 8'h1D);
                    if (d[0]) begin
                        m_civ[s] = m_piv[s]; m_piv[s] = (m_piv[s] + 1) % 32;
                        m_st[s] = 1; m_start[s] = 1;
                    end else m_st[s] = 0;
                end
            end else if ((sz == BY || sz == WD) && o == 6) begin
                hit = 1;
                if (d[2]) m_lvbci[s] = 0;
            end else if (sz == DW && o == 0) begin
                hit = 1;
                m_base[s] = d & 32'hFFFF_FFFC;
            end
        end else if (sz == DW && a == 6'h2C) begin
            hit = 1;
            if (d[2]) m_warm = 1;
            if (d[1]) begin
                m_cold = 1;
                for (int k = 0; k < 3; k++) clear_stream(k);
            end
            if (!d[1] && !d[2]) m_gctl = d & 32'hF9;
        end else if (sz == DW && a == 6'h30) begin
            hit = 1;
            m_flags  = m_flags & ~d[15:8];
            m_sticky = m_sticky | d[23:16];
        end
        if (!hit) m_cwr = (m_cwr + 1) & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) clear_stream(k);
            m_gctl = 0; m_flags = 0; m_sticky = 0; m_crd = 0; m_cwr = 0;
            m_rdata = 0; m_rdv = 0; m_start = 0; m_clr = 0; m_warm = 0; m_cold = 0;
        end else begin
            m_start = 0; m_clr = 0; m_warm = 0; m_cold = 0;
            m_rdv = b_rd;
            if (b_rd) m_rdata = model_read(b_addr, b_size);
            if (b_wr) model_write(b_addr, b_size, b_wdata);
            m_flags = m_flags | b_evt;
            for (int k = 0; k < 3; k++)
                if (b_halt[k] && m_st[k] == 1) begin
                    m_st[k] = 2; m_celv[k] = 1; m_lvbci[k] = 1;
                end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] mrun;
            for (int k = 0; k < 3; k++) mrun[k] = m_ctl[k][0];
            chk("strm_run", 32'(strm_run), 32'(mrun));
            chk("strm_start", 32'(strm_start), 32'(m_start));
            chk("strm_clr", 32'(strm_clr), 32'(m_clr));
            chk("link_warm", 32'(link_warm), 32'(m_warm));
            chk("link_cold", 32'(link_cold), 32'(m_cold));
            chk("unimp_rd_cnt", 32'(unimp_rd_cnt), 32'(m_crd));
            chk("unimp_wr_cnt", 32'(unimp_wr_cnt), 32'(m_cwr));
            if (m_rdv) chk("bus_rdata", bus_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    task automatic wr(logic [5:0] a, logic [1:0] sz, logic [31:0] d);
        b_wr = 1; b_addr = a; b_size = sz; b_wdata = d;
        @(negedge clk);
        b_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, logic [1:0] sz);
        b_rd = 1; b_addr = a; b_size = sz;
        @(negedge clk);
        b_rd = 0;
        @(negedge clk);
    endtask

    task automatic halt(int s);
        b_halt[s] = 1;
        @(negedge clk);
        b_halt = 0;
    endtask

    task automatic dump_stream(int s);
        logic [5:0] b = 6'(s * 16);
        rd(b, DW); rd(b + 6'h4, DW); rd(b + 6'h8, DW);
        rd(b + 6'h4, BY); rd(b + 6'h5, BY); rd(b + 6'h6, BY);
        rd(b + 6'hA, BY); rd(b + 6'hB, BY); rd(b + 6'h6, WD); rd(b + 6'h8, WD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R12";
        for (int s = 0; s < 3; s++) dump_stream(s);
        rd(6'h2C, DW); rd(6'h30, DW);

        cur_req = "R1";
        rd(6'h34, BY); rd(6'h2C, BY); rd(6'h3C, DW); rd(6'h2E, WD);
        wr(6'h20, DW, 32'hCAFE_0004); rd(6'h20, DW);

        cur_req = "R2";
        wr(6'h00, DW, 32'h1234_5677); rd(6'h00, DW);
        wr(6'h10, DW, 32'hFFFF_FFFF); rd(6'h10, DW);

        cur_req = "R13";
        wr(6'h00, WD, 32'h0000_0000); wr(6'h05, WD, 32'h7); wr(6'h0B, DW, 32'h1);
        wr(6'h00, BY, 32'h0); wr(6'h2C, BY, 32'h2); wr(6'h06, BADSZ, 32'h4);
        wr(6'h04, BY, 32'h3); wr(6'h0A, BY, 32'h3);
        dump_stream(0);

        cur_req = "R5";
        wr(6'h1B, BY, 32'h0000_00FD); dump_stream(1);
        wr(6'h1B, BY, 32'h0000_0000); dump_stream(1);
        wr(6'h1B, BY, 32'h0000_0001); dump_stream(1);

        cur_req = "R7";
        halt(0); dump_stream(0);
        halt(1); @(negedge clk); dump_stream(1);
        halt(1); dump_stream(1);

        cur_req = "R3";
        wr(6'h05, BY, 32'h0000_0027); dump_stream(0);
        wr(6'h15, BY, 32'h0000_0025); dump_stream(1);

        cur_req = "R6";
        halt(1); rd(6'h16, WD);
        wr(6'h16, BY, 32'h0000_00FB); rd(6'h16, WD);
        wr(6'h16, WD, 32'h0000_FFFF); rd(6'h16, WD);

        cur_req = "R4";
        wr(6'h20, DW, 32'h8000_0010); wr(6'h2B, BY, 32'h0000_0011);
        wr(6'h2B, BY, 32'h0000_00FF); dump_stream(2);

        cur_req = "R3";
        wr(6'h0B, BY, 32'h0000_0001);
        for (int n = 0; n < 35; n++) begin
            halt(0);
            wr(6'h05, BY, 32'(n));
        end
        dump_stream(0);

        cur_req = "R8";
        wr(6'h2C, DW, 32'hFFFF_FFF9); rd(6'h2C, DW);
        wr(6'h2C, DW, 32'h0000_0004); rd(6'h2C, DW);
        wr(6'h2B, BY, 32'h0000_0001); wr(6'h20, DW, 32'h0000_1000);
        wr(6'h2C, DW, 32'h0000_0002); rd(6'h2C, DW);
        for (int s = 0; s < 3; s++) dump_stream(s);

        cur_req = "R9";
        b_evt = 8'h81; @(negedge clk); b_evt = 0;
        rd(6'h30, DW);
        wr(6'h30, DW, 32'h00A5_01FF); rd(6'h30, DW);
        b_ro = 8'h3C;
        b_evt = 8'h80; wr(6'h30, DW, 32'h0000_8000); b_evt = 0; rd(6'h30, DW);

        cur_req = "R10";
        rd(6'h07, BY); rd(6'h09, BY); rd(6'h04, WD); rd(6'h0C, DW);
        rd(6'h35, BY); rd(6'h30, WD); rd(6'h1B, BADSZ);

        cur_req = "R11";
        for (int n = 0; n < 10; n++) begin
            rd(6'h3F, BY);
            wr(6'h3F, BY, 32'h0);
        end
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule